// File: doc/BRIEF.md
# Floating-Point Sign Injection and Min/Max Unit

This unit takes two IEEE-754 single-precision operands and applies either a sign-injection operation or a minimum/maximum selection. A one-bit group select chooses between the two families. A two-bit sub-code then picks the operation inside the chosen family. The core logic is purely combinational. One register stage then captures the result and the invalid-operation flag, and a valid bit travels alongside them, so the latency is fixed at one cycle. The result is delivered in a 64-bit register value with the unused upper bits cleared.

Sign injection builds a result from the magnitude of operand A and a sign derived from operand B. It never looks at NaN-ness and never raises a flag. Min/max orders the operands as signed magnitudes, so negative zero sits below positive zero. NaNs get special treatment. A signaling NaN makes the unit return the other operand and raise invalid, and operand B is checked before operand A. A lone quiet NaN gives way to the numeric operand. If both operands are NaN and neither case above applies, the unit returns a canonical quiet NaN. The `FLEN` parameter may widen the datapath to 64 bits.

Top module: `fp_signmm_unit`

## Requirements
- R1: With group 0 and sub-code 0, the result is operand A with its bit 31 replaced by bit 31 of operand B.
- R2: With group 0 and sub-code 1, the result is operand A with its bit 31 replaced by the inverse of bit 31 of operand B.
- R3: With group 0 and sub-code 2, the result is operand A with its bit 31 replaced by the XOR of both operands' bit 31.
- R4: Sign injection never sets the invalid flag and leaves bits 30:0 of operand A unchanged, even when A is a signaling NaN (exponent bits 30:23 all ones, bit 22 clear, bits 21:0 nonzero).
- R5: With group 1, sub-code 0 returns the smaller operand and sub-code 1 returns the larger. Ordering is by sign and magnitude, and when the two operands are equal operand A is returned.
- R6: Minimum of -0 (0x80000000) and +0 (0x00000000) is -0, and maximum of them is +0, in either operand order.
- R7: In the min/max group, if operand B is a signaling NaN the result is operand A and invalid is set. Otherwise, if operand A is a signaling NaN, the result is operand B and invalid is set.
- R8: In the min/max group, when exactly one operand is a quiet NaN (exponent all ones, bit 22 set) and neither operand is signaling, the other operand is returned and invalid stays clear.
- R9: In the min/max group, when both operands are quiet NaNs the result is 0x7FC00000 and invalid stays clear.
- R10: The output bus is 64 bits wide. The 32-bit result sits in bits 31:0 and bits 63:32 are zero.
- R11: When in_valid is high at a clock edge, out_valid, the result and the flag reflect those inputs after that edge. When in_valid is low, out_valid drops and the result and flag hold their last values.
- R12: Unsupported codes (group 0 with sub-code 3, group 1 with sub-code 2 or 3) give a zero result with invalid clear.
- R13: While reset is active, out_valid, the result and the flag are all zero after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and codes are valid this cycle |
| op_group | input | 1 | 0 = sign injection, 1 = min/max |
| op_sub | input | 2 | Operation within the group |
| opnd_a | input | FLEN | Operand A |
| opnd_b | input | FLEN | Operand B |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Zero-extended registered result |
| out_invalid | output | 1 | Registered invalid-operation flag |

## Verification
Sign injection is driven with all four sign pairings of A and B. This separates the copy, invert and XOR rules. A signaling-NaN operand A then shows that no flag appears and that the payload survives. Min/max is exercised with:
- two positives, two negatives and mixed signs, which tell magnitude ordering apart from signed ordering;
- both zero orderings, which expose a compare that treats the zeros as equal;
- equal operands.

The NaN patterns are a signaling NaN in each position, a signaling NaN in both, a quiet NaN against a number in each position, and two quiet NaNs. Together they separate the B-before-A priority, the quiet-NaN pass-through and the canonical result. Idle cycles between operations show that the result holds, and the unsupported codes show the zero result.

// File: rtl/fpsm_pkg.sv
`timescale 1ns/1ps
// Package: shared types and codes for the sign-injection / min-max unit.
// Assumes: operation codes are fixed by the instruction decode that drives the unit.
package fpsm_pkg;

    typedef enum logic {
        GRP_SIGN   = 1'b0,
        GRP_MINMAX = 1'b1
    } op_grp_e;

    localparam logic [1:0] SJ_COPY = 2'd0;
    localparam logic [1:0] SJ_NEG  = 2'd1;
    localparam logic [1:0] SJ_XOR  = 2'd2;
    localparam logic [1:0] MM_MIN  = 2'd0;
    localparam logic [1:0] MM_MAX  = 2'd1;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } fp_class_t;

endpackage

// File: rtl/fpsm_classify.sv
`timescale 1ns/1ps
// Module: fpsm_classify
// Flags an operand as NaN and, if so, as signaling (quiet bit clear).
// Assumes: IEEE-754 binary layout with EXPW exponent bits under the sign.
module fpsm_classify
    import fpsm_pkg::*;
#(
    parameter int FLEN = 32,
    parameter int EXPW = 8
) (
    input  logic [FLEN-1:0] opnd,
    output fp_class_t       cls
);
    localparam int MANW = FLEN - 1 - EXPW;

    logic exp_ones;
    logic man_nz;

    // Decode the exponent and mantissa fields into NaN class bits.
    always_comb begin
        exp_ones    = &opnd[FLEN-2 -: EXPW];
        man_nz      = |opnd[MANW-1:0];
        cls.is_nan  = exp_ones && man_nz;
        cls.is_snan = exp_ones && man_nz && !opnd[MANW-1];
    end
endmodule

// File: rtl/fpsm_sgnj.sv
`timescale 1ns/1ps
// Module: fpsm_sgnj
// Replaces operand A's sign by a sign derived from operand B; never flags.
// Assumes: code 3 is unsupported and reported through code_ok.
module fpsm_sgnj
    import fpsm_pkg::*;
#(
    parameter int FLEN = 32
) (
    input  logic [FLEN-1:0] opnd_a,
    input  logic [FLEN-1:0] opnd_b,
    input  logic [1:0]      sub,
    output logic [FLEN-1:0] res,
    output logic            code_ok
);
    logic sgn;

    // Choose the injected sign bit for the requested sub-operation.
    always_comb begin
        code_ok = 1'b1;
        unique case (sub)
            SJ_COPY: sgn = opnd_b[FLEN-1];
            SJ_NEG:  sgn = ~opnd_b[FLEN-1];
            SJ_XOR:  sgn = opnd_a[FLEN-1] ^ opnd_b[FLEN-1];
            default: begin
                sgn     = 1'b0;
                code_ok = 1'b0;
            end
        endcase
        res = {sgn, opnd_a[FLEN-2:0]};
    end
endmodule

// File: rtl/fpsm_minmax.sv
`timescale 1ns/1ps
// Module: fpsm_minmax
// Selects the minimum or maximum of two operands with NaN handling:
// signaling NaN in B wins priority, then signaling NaN in A, then quiet NaNs.
// Assumes: class inputs come from fpsm_classify on the same operands.
module fpsm_minmax
    import fpsm_pkg::*;
#(
    parameter int FLEN = 32,
    parameter int EXPW = 8
) (
    input  logic [FLEN-1:0] opnd_a,
    input  logic [FLEN-1:0] opnd_b,
    input  fp_class_t       cls_a,
    input  fp_class_t       cls_b,
    input  logic [1:0]      sub,
    output logic [FLEN-1:0] res,
    output logic            invalid,
    output logic            code_ok
);
    localparam int MANW = FLEN - 1 - EXPW;
    localparam logic [FLEN-1:0] CANON_NAN = {1'b0, {EXPW{1'b1}}, 1'b1, {(MANW-1){1'b0}}};

    logic a_lt_b;
    logic pick_a;

    // Signed-magnitude ordering; -0 orders below +0 through the sign test.
    always_comb begin
        if (opnd_a[FLEN-1] != opnd_b[FLEN-1])
            a_lt_b = opnd_a[FLEN-1];
        else if (!opnd_a[FLEN-1])
            a_lt_b = opnd_a[FLEN-2:0] < opnd_b[FLEN-2:0];
        else
            a_lt_b = opnd_a[FLEN-2:0] > opnd_b[FLEN-2:0];
        pick_a = (sub == MM_MIN) ? (a_lt_b || opnd_a == opnd_b) : !a_lt_b;
    end

    // Apply NaN priority, then the numeric choice.
    always_comb begin
        code_ok = (sub == MM_MIN) || (sub == MM_MAX);
        invalid = 1'b0;
        if (cls_b.is_snan) begin
            res     = opnd_a;
            invalid = 1'b1;
        end else if (cls_a.is_snan) begin
            res     = opnd_b;
            invalid = 1'b1;
        end else if (cls_a.is_nan && cls_b.is_nan) begin
            res = CANON_NAN;
        end else if (cls_a.is_nan) begin
            res = opnd_b;
        end else if (cls_b.is_nan) begin
            res = opnd_a;
        end else begin
            res = pick_a ? opnd_a : opnd_b;
        end
    end
endmodule

// File: rtl/fp_signmm_unit.sv
`timescale 1ns/1ps
// Module: fp_signmm_unit (top)
// Sign injection and min/max on two floating-point operands, one register
// stage on the output, result zero-extended to 64 bits.
// Assumes: FLEN is 32 or 64; inputs are sampled only when in_valid is high.
module fp_signmm_unit
    import fpsm_pkg::*;
#(
    parameter int FLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            op_group,
    input  logic [1:0]      op_sub,
    input  logic [FLEN-1:0] opnd_a,
    input  logic [FLEN-1:0] opnd_b,
    output logic            out_valid,
    output logic [63:0]     out_result,
    output logic            out_invalid
);
    localparam int OUT_W = 64;
    localparam int EXPW  = (FLEN == 64) ? 11 : 8;
    localparam int NOPND = 2;

    logic [FLEN-1:0] opnd [NOPND];
    fp_class_t       cls  [NOPND];
    logic [FLEN-1:0] sj_res, mm_res, nxt_res, res_q;
    logic            sj_ok, mm_ok, mm_inv, nxt_inv;
    op_grp_e         grp;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;
    assign grp     = op_grp_e'(op_group);

    for (genvar g = 0; g < NOPND; g++) begin : g_cls
        fpsm_classify #(.FLEN(FLEN), .EXPW(EXPW)) u_cls (
            .opnd (opnd[g]),
            .cls  (cls[g])
        );
    end

    fpsm_sgnj #(.FLEN(FLEN)) u_sgnj (
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .sub     (op_sub),
        .res     (sj_res),
        .code_ok (sj_ok)
    );

    fpsm_minmax #(.FLEN(FLEN), .EXPW(EXPW)) u_mm (
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .cls_a   (cls[0]),
        .cls_b   (cls[1]),
        .sub     (op_sub),
        .res     (mm_res),
        .invalid (mm_inv),
        .code_ok (mm_ok)
    );

    // Pick the active group's result; unsupported codes yield zero, no flag.
    always_comb begin
        nxt_res = '0;
        nxt_inv = 1'b0;
        if (grp == GRP_SIGN) begin
            if (sj_ok) nxt_res = sj_res;
        end else if (mm_ok) begin
            nxt_res = mm_res;
            nxt_inv = mm_inv;
        end
    end

    // Output register: loads on in_valid, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            res_q       <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q       <= nxt_res;
                out_invalid <= nxt_inv;
            end
        end
    end

    if (FLEN < OUT_W) begin : g_zext
        assign out_result = {{(OUT_W-FLEN){1'b0}}, res_q};
    end else begin : g_full
        assign out_result = res_q;
    end
endmodule

// File: rtl/fp_signmm_unit_chk.sv
`timescale 1ns/1ps
// Module: fp_signmm_unit_chk
// Temporal checks on the unit's ports, attached by bind.
// Assumes: FLEN matches the bound instance.
module fp_signmm_unit_chk #(
    parameter int FLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            op_group,
    input logic [1:0]      op_sub,
    input logic [FLEN-1:0] opnd_a,
    input logic [FLEN-1:0] opnd_b,
    input logic            out_valid,
    input logic [63:0]     out_result,
    input logic            out_invalid
);
    localparam int EXPW = (FLEN == 64) ? 11 : 8;
    localparam int MANW = FLEN - 1 - EXPW;
    localparam logic [FLEN-1:0] CANON = {1'b0, {EXPW{1'b1}}, 1'b1, {(MANW-1){1'b0}}};

    // R11: valid travels with one cycle of latency.
    p_valid_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_dn_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R11: result and flag hold during idle cycles.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_invalid)));
    // R4: sign injection raises no flag.
    p_sj_noflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_group) |=> !out_invalid);
    // R4: sign injection keeps operand A's exponent and mantissa.
    p_sj_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_group && op_sub != 2'd3)
        |=> out_result[FLEN-2:0] == $past(opnd_a[FLEN-2:0]));
    // R7: min/max result is an operand or the canonical NaN.
    p_mm_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_group && !op_sub[1])
        |=> (out_result[FLEN-1:0] == $past(opnd_a) ||
             out_result[FLEN-1:0] == $past(opnd_b) ||
             out_result[FLEN-1:0] == CANON));
endmodule

bind fp_signmm_unit fp_signmm_unit_chk #(.FLEN(FLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_group    (op_group),
    .op_sub      (op_sub),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid)
);

// File: tb/fp_signmm_unit_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the unit on every cycle.
module fp_signmm_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_group = 1'b0;
    logic [1:0]  op_sub = 2'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        exp_vld = 1'b0;
    logic [31:0] exp_res = '0;
    logic        exp_inv = 1'b0;

    always #10 clk = ~clk;

    fp_signmm_unit #(.FLEN(32)) u_fp_signmm_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_group(op_group),
        .op_sub(op_sub), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid)
    );

    function automatic bit f_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit f_snan(logic [31:0] x);
        return f_nan(x) && !x[22];
    endfunction

    // Signed ordering key: -0 maps just below +0.
    function automatic longint f_key(logic [31:0] x);
        longint m = longint'({33'b0, x[30:0]});
        return x[31] ? (-m - 1) : m;
    endfunction

    task automatic ref_op(input logic g, input logic [1:0] s, input logic [31:0] a,
                          input logic [31:0] b, output logic [31:0] r, output logic f);
        r = 32'h0;
        f = 1'b0;
        if (!g) begin
            case (s)
                2'd0: r = {b[31], a[30:0]};
                2'd1: r = {~b[31], a[30:0]};
                2'd2: r = {a[31] ^ b[31], a[30:0]};
                default: r = 32'h0;
            endcase
        end else if (s < 2) begin
            if (f_snan(b)) begin r = a; f = 1'b1; end
            else if (f_snan(a)) begin r = b; f = 1'b1; end
            else if (f_nan(a) && f_nan(b)) r = 32'h7FC00000;
            else if (f_nan(a)) r = b;
            else if (f_nan(b)) r = a;
            else if (s == 0) r = (f_key(a) <= f_key(b)) ? a : b;
            else r = (f_key(a) >= f_key(b)) ? a : b;
        end
    endtask

    task automatic compare(input string tag);
        logic [65:0] act, exp;
        act = {out_valid, out_invalid, out_result};
        exp = {exp_vld, exp_inv, 32'h0, exp_res};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual vld=%b inv=%b res=%h expected vld=%b inv=%b res=%h",
                     tag, out_valid, out_invalid, out_result, exp_vld, exp_inv, {32'h0, exp_res});
        end
    endtask

    task automatic step(input logic v, input logic g, input logic [1:0] s,
                        input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        in_valid = v; op_group = g; op_sub = s; opnd_a = a; opnd_b = b;
        exp_vld = v;
        if (v) ref_op(g, s, a, b, exp_res, exp_inv);
        @(posedge clk);
        #5;
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R13: reset state
        repeat (2) @(posedge clk);
        #5;
        compare("R13");
        @(negedge clk);
        rst_n = 1'b1;

        // Sign injection over all sign pairings (R1, R2, R3, R10)
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a = {i[1], 31'h3FC00000};
            logic [31:0] b = {i[0], 31'h40490FDB};
            step(1, 0, 2'd0, a, b, "R1");
            step(1, 0, 2'd1, a, b, "R2");
            step(1, 0, 2'd2, a, b, "R3");
        end
        step(1, 0, 2'd0, 32'h0000FFFF, 32'h80000000, "R10");
        // R4: signaling NaN in A passes through sign injection without a flag
        step(1, 0, 2'd1, 32'h7F800001, 32'h00000000, "R4");
        step(1, 0, 2'd2, 32'hFF812345, 32'hFFFFFFFF, "R4");

        // R5: numeric min/max
        step(1, 1, 2'd0, 32'h3F800000, 32'h40000000, "R5");
        step(1, 1, 2'd1, 32'h3F800000, 32'h40000000, "R5");
        step(1, 1, 2'd0, 32'hBF800000, 32'hC0000000, "R5");
        step(1, 1, 2'd1, 32'hBF800000, 32'hC0000000, "R5");
        step(1, 1, 2'd0, 32'h40000000, 32'hBF800000, "R5");
        step(1, 1, 2'd1, 32'hBF800000, 32'h7F800000, "R5");
        step(1, 1, 2'd0, 32'h41200000, 32'h41200000, "R5");
        // R6: signed zeros in both orders
        step(1, 1, 2'd0, 32'h00000000, 32'h80000000, "R6");
        step(1, 1, 2'd0, 32'h80000000, 32'h00000000, "R6");
        step(1, 1, 2'd1, 32'h00000000, 32'h80000000, "R6");
        step(1, 1, 2'd1, 32'h80000000, 32'h00000000, "R6");
        // R7: signaling NaN priority
        step(1, 1, 2'd0, 32'h3F800000, 32'h7F800001, "R7");
        step(1, 1, 2'd1, 32'hFF800005, 32'h3F800000, "R7");
        step(1, 1, 2'd0, 32'h7F800002, 32'hFF800003, "R7");
        step(1, 1, 2'd1, 32'h7FC00000, 32'h7FA00000, "R7");
        // R8: single quiet NaN
        step(1, 1, 2'd0, 32'h7FC00000, 32'hC0000000, "R8");
        step(1, 1, 2'd1, 32'h40000000, 32'hFFC00001, "R8");
        // R9: two quiet NaNs
        step(1, 1, 2'd0, 32'hFFC00001, 32'h7FC12345, "R9");
        step(1, 1, 2'd1, 32'h7FE00000, 32'h7FC00000, "R9");

        // R11: idle cycles hold the last value, then back-to-back operations
        step(1, 1, 2'd0, 32'h3F800000, 32'h7F800001, "R11");
        step(0, 0, 2'd0, 32'h12345678, 32'h9ABCDEF0, "R11");
        step(0, 1, 2'd1, 32'hFFFFFFFF, 32'h7F800001, "R11");
        step(1, 0, 2'd1, 32'h12345678, 32'h00000000, "R11");
        step(1, 1, 2'd1, 32'h12345678, 32'h92345678, "R11");

        // R12: unsupported codes
        step(1, 0, 2'd3, 32'h3F800000, 32'hBF800000, "R12");
        step(1, 1, 2'd2, 32'h3F800000, 32'h7F800001, "R12");
        step(1, 1, 2'd3, 32'h7F800001, 32'h3F800000, "R12");

        // R13: reset reasserted clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        exp_vld = 1'b0; exp_res = '0; exp_inv = 1'b0;
        @(posedge clk);
        #5;
        compare("R13");

        finish_run();
    end
endmodule